// File: doc/BRIEF.md
# Converter Control Register File with Parallel Bus Access

This block is the configuration front end of a data converter. A host reaches it over an asynchronous parallel bus with a 2-bit address, an active-low select, an active-low write strobe, an active-low read enable and a 14-bit bidirectional data bus. Three writable registers hold the gain code, a signed offset byte and a control word. A fourth address returns the most recent conversion result, which the datapath presents on an input port.

Bus writes are not clocked by the system clock. The whole bus bundle passes through a synchronizer chain. A rising edge of the strobe, seen with select low, commits the snapshot taken while the strobe was still low. Writing a one to bit 0 of the result address clears all three registers at once. The decoded fields go straight to the datapath as individual control outputs.

Top module: `conv_ctrl_regs`

## Requirements
- R1: After rst_ni is asserted, every configuration output is zero and addresses 1, 2 and 3 read back as zero. This means gain 0 dB, no offset, internal reference, unsigned output, test mode 0 and power on.
- R2: A write to address 1 loads data bits 2:0 into gain_o. The value is a dB code from 0 to 7.
- R3: A write to address 2 loads data bits 7:0 into offset_o, a two's complement byte.
- R4: A write to address 3 loads the control word. Bit 13 drives pwr_down_o, bit 12 drives ext_ref_o, bit 11 drives twos_fmt_o, bits 10:8 drive test_mode_o and bit 7 drives offset_en_o.
- R5: A write commits only on the rising edge of we_ni while cs_ni is low. While the strobe is still low the outputs keep their old values. A strobe seen with cs_ni high changes nothing.
- R6: A write to address 0 with data bit 0 set clears the gain, offset and control registers. With bit 0 clear it has no effect.
- R7: data_io is driven only while cs_ni and oe_ni are both low. Otherwise it is high-impedance.
- R8: A read of address 0 returns result_i.
- R9: Register bits with no function read back as zero, and any value written to them is discarded. Address 1 holds only bits 2:0, address 2 only bits 7:0 and address 3 only bits 13:7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Bus select, active low |
| we_ni | input | 1 | Write strobe, active low; commits on its rising edge |
| oe_ni | input | 1 | Read enable, active low |
| addr_i | input | 2 | Register address |
| data_io | inout | 14 | Bidirectional data bus |
| result_i | input | 14 | Latest conversion result from the datapath |
| gain_o | output | 3 | Gain code, 1 dB per step |
| offset_o | output | 8 | Signed offset added by the datapath |
| pwr_down_o | output | 1 | Power-down request |
| ext_ref_o | output | 1 | External reference select |
| twos_fmt_o | output | 1 | Two's complement output format |
| test_mode_o | output | 3 | Test-mode code |
| offset_en_o | output | 1 | Enables offset addition |

## Verification
The bench builds the block with its default parameters: a 14-bit bus, a 3-bit gain, an 8-bit offset, a 3-bit test-mode code and a two-stage synchronizer. These values put the control field positions at bits 13 down to 7, so every position named in R4 and R9 is reached by all-ones and alternating patterns. The two-stage depth keeps the commit latency short, so a strobe held low for several clocks shows that nothing commits before the rising edge.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    ADDR_RESULT = 2'd0,
    ADDR_GAIN   = 2'd1,
    ADDR_OFFSET = 2'd2,
    ADDR_CTRL   = 2'd3
  } ccr_addr_e;
endpackage

// File: rtl/ccr_wr_sync.sv
module ccr_wr_sync #(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 2,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_pulse_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int BW   = 2 + ADDR_W + DATA_W;
  localparam int CS_B = BW - 1;
  localparam int WE_B = BW - 2;
  localparam logic [BW-1:0] IDLE = {2'b11, {(ADDR_W + DATA_W){1'b0}}};

  // stages 0..STAGES-1 synchronize; stage STAGES holds the previous sample
  logic [BW-1:0] stg_q [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= STAGES; i++) stg_q[i] <= IDLE;
    end else begin
      stg_q[0] <= {cs_ni, we_ni, addr_i, data_i};
      for (int i = 1; i <= STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  logic strobe_rise;
  assign strobe_rise = stg_q[STAGES-1][WE_B] && !stg_q[STAGES][WE_B];
  assign wr_pulse_o  = strobe_rise && !stg_q[STAGES][CS_B];
  assign wr_addr_o   = stg_q[STAGES][DATA_W +: ADDR_W];
  assign wr_data_o   = stg_q[STAGES][DATA_W-1:0];
endmodule

// File: rtl/ccr_reg_bank.sv
module ccr_reg_bank
  import ccr_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int GAIN_W = 3,
  parameter int OFS_W  = 8,
  parameter int TM_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_pulse_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [GAIN_W-1:0]   gain_q_o,
  output logic [OFS_W-1:0]    ofs_q_o,
  output logic [TM_W+3:0]     ctl_q_o
);
  localparam int CTL_W   = TM_W + 4;
  localparam int CTL_LSB = DATA_W - CTL_W;

  logic sw_clear;
  assign sw_clear = wr_pulse_i && (wr_addr_i == ADDR_RESULT) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q_o <= '0;
      ofs_q_o  <= '0;
      ctl_q_o  <= '0;
    end else if (sw_clear) begin
      gain_q_o <= '0;
      ofs_q_o  <= '0;
      ctl_q_o  <= '0;
    end else if (wr_pulse_i) begin
      case (wr_addr_i)
        ADDR_GAIN:   gain_q_o <= wr_data_i[GAIN_W-1:0];
        ADDR_OFFSET: ofs_q_o  <= wr_data_i[OFS_W-1:0];
        ADDR_CTRL:   ctl_q_o  <= wr_data_i[DATA_W-1:CTL_LSB];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ccr_rd_mux.sv
module ccr_rd_mux
  import ccr_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int GAIN_W = 3,
  parameter int OFS_W  = 8,
  parameter int TM_W   = 3
) (
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [TM_W+3:0]   ctl_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int CTL_LSB = DATA_W - (TM_W + 4);

  always_comb begin
    unique case (addr_i)
      ADDR_RESULT: rd_data_o = result_i;
      ADDR_GAIN:   rd_data_o = {{(DATA_W-GAIN_W){1'b0}}, gain_i};
      ADDR_OFFSET: rd_data_o = {{(DATA_W-OFS_W){1'b0}}, ofs_i};
      default:     rd_data_o = {ctl_i, {CTL_LSB{1'b0}}};
    endcase
  end
endmodule

// File: rtl/conv_ctrl_regs.sv
module conv_ctrl_regs #(
  parameter int DATA_W = 14,
  parameter int GAIN_W = 3,
  parameter int OFS_W  = 8,
  parameter int TM_W   = 3,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [1:0]        addr_i,
  inout  wire  [DATA_W-1:0] data_io,
  input  logic [DATA_W-1:0] result_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic              pwr_down_o,
  output logic              ext_ref_o,
  output logic              twos_fmt_o,
  output logic [TM_W-1:0]   test_mode_o,
  output logic              offset_en_o
);
  localparam int CTL_W = TM_W + 4;

  logic              wr_pulse;
  logic [1:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] rd_data;
  logic              rd_en;

  ccr_wr_sync #(.DATA_W(DATA_W), .ADDR_W(2), .STAGES(STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .we_ni      (we_ni),
    .addr_i     (addr_i),
    .data_i     (data_io),
    .wr_pulse_o (wr_pulse),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  ccr_reg_bank #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .TM_W(TM_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_pulse_i (wr_pulse),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .gain_q_o   (gain_o),
    .ofs_q_o    (offset_o),
    .ctl_q_o    (ctl_q)
  );

  ccr_rd_mux #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .TM_W(TM_W)) u_rd (
    .addr_i    (addr_i),
    .result_i  (result_i),
    .gain_i    (gain_o),
    .ofs_i     (offset_o),
    .ctl_i     (ctl_q),
    .rd_data_o (rd_data)
  );

  assign pwr_down_o  = ctl_q[CTL_W-1];
  assign ext_ref_o   = ctl_q[CTL_W-2];
  assign twos_fmt_o  = ctl_q[CTL_W-3];
  assign test_mode_o = ctl_q[CTL_W-4 -: TM_W];
  assign offset_en_o = ctl_q[0];

  assign rd_en   = !cs_ni && !oe_ni;
  assign data_io = rd_en ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/conv_ctrl_regs_chk.sv
module conv_ctrl_regs_chk #(
  parameter int DATA_W = 14,
  parameter int GAIN_W = 3,
  parameter int OFS_W  = 8,
  parameter int TM_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_pulse,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [GAIN_W-1:0] gain_o,
  input logic [OFS_W-1:0]  offset_o,
  input logic              pwr_down_o,
  input logic              ext_ref_o,
  input logic              twos_fmt_o,
  input logic [TM_W-1:0]   test_mode_o,
  input logic              offset_en_o
);
  localparam int CTL_LSB = DATA_W - (TM_W + 4);

  logic [TM_W+3:0] ctl_view;
  assign ctl_view = {pwr_down_o, ext_ref_o, twos_fmt_o, test_mode_o, offset_en_o};

  AST_GAIN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse && wr_addr == 2'd1 |=> gain_o == $past(wr_data[GAIN_W-1:0])); // R2

  AST_OFFSET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse && wr_addr == 2'd2 |=> offset_o == $past(wr_data[OFS_W-1:0])); // R3

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse && wr_addr == 2'd3 |=> ctl_view == $past(wr_data[DATA_W-1:CTL_LSB])); // R4

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pulse |=> $stable(gain_o) && $stable(offset_o) && $stable(ctl_view)); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |=> !wr_pulse); // R5

  AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse && wr_addr == 2'd0 && wr_data[0]
    |=> gain_o == '0 && offset_o == '0 && ctl_view == '0); // R6

  AST_ZERO_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse && wr_addr == 2'd0 && !wr_data[0]
    |=> $stable(gain_o) && $stable(offset_o) && $stable(ctl_view)); // R6
endmodule

bind conv_ctrl_regs conv_ctrl_regs_chk #(
  .DATA_W(DATA_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .TM_W(TM_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_pulse    (wr_pulse),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .gain_o      (gain_o),
  .offset_o    (offset_o),
  .pwr_down_o  (pwr_down_o),
  .ext_ref_o   (ext_ref_o),
  .twos_fmt_o  (twos_fmt_o),
  .test_mode_o (test_mode_o),
  .offset_en_o (offset_en_o)
);

// File: tb/conv_ctrl_regs_tb_top.sv
module conv_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [13:0] tb_drv = '0;
  logic        tb_en = 1'b0;
  logic [13:0] result = '0;
  wire  [13:0] bus;
  logic [2:0]  gain, tm;
  logic [7:0]  ofs;
  logic        pwd, eref, tfmt, ofe;

  assign bus = tb_en ? tb_drv : 14'bz;

  always #10 clk = ~clk;

  conv_ctrl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_io(bus), .result_i(result),
    .gain_o(gain), .offset_o(ofs), .pwr_down_o(pwd), .ext_ref_o(eref),
    .twos_fmt_o(tfmt), .test_mode_o(tm), .offset_en_o(ofe)
  );

  typedef struct {
    int          kind;   // 0 bus value, 1 config outputs, 2 bus floating
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;

  // reference model, built from the requirements
  logic [2:0] m_gain = '0;
  logic [7:0] m_ofs  = '0;
  logic [6:0] m_ctl  = '0;

  function automatic void model_wr(logic [1:0] a, logic [13:0] d);
    case (a)
      2'd0: if (d[0]) begin m_gain = '0; m_ofs = '0; m_ctl = '0; end
      2'd1: m_gain = d[2:0];
      2'd2: m_ofs  = d[7:0];
      default: m_ctl = d[13:7];
    endcase
  endfunction

  // monitor: compares on the falling edge, away from the driving points
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      n_chk++;
      case (it.kind)
        0: begin
          act = {18'd0, bus};
          if (bus !== it.exp[13:0]) begin
            n_fail++;
            $display("FAIL %s: bus actual %h expected %h", it.tag, bus, it.exp[13:0]);
          end
        end
        1: begin
          act = {14'd0, pwd, eref, tfmt, tm, ofe, ofs, gain};
          if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: cfg actual %h expected %h", it.tag, act, it.exp);
          end
        end
        default: begin
          if (bus !== 14'bz) begin
            n_fail++;
            $display("FAIL %s: bus actual %b expected all z", it.tag, bus);
          end
        end
      endcase
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [13:0] d, logic sel_n = 1'b0);
    step();
    cs_n = sel_n; addr = a; tb_drv = d; tb_en = 1'b1; we_n = 1'b0;
    repeat (3) step();
    we_n = 1'b1;
    repeat (2) step();
    cs_n = 1'b1; tb_en = 1'b0;
    repeat (3) step();
    if (!sel_n) model_wr(a, d);
  endtask

  task automatic exp_cfg(string tag);
    push(1, {14'd0, m_ctl, m_ofs, m_gain}, tag);
    step();
  endtask

  task automatic rd(logic [1:0] a, logic [13:0] e, string tag);
    step();
    cs_n = 1'b0; oe_n = 1'b0; addr = a;
    step();
    push(0, {18'd0, e}, tag);
    step();
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic chk_z(logic c, logic o, string tag);
    step();
    cs_n = c; oe_n = o; addr = 2'd1;
    step();
    push(2, '0, tag);
    step();
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (2) step();

    exp_cfg("R1 reset outputs");
    rd(2'd1, 14'h0, "R1 reset gain read");
    rd(2'd2, 14'h0, "R1 reset offset read");
    rd(2'd3, 14'h0, "R1 reset ctrl read");

    wr(2'd1, 14'h3FFD);
    exp_cfg("R2 gain code 5");
    rd(2'd1, 14'h0005, "R9 gain upper bits read zero");
    wr(2'd1, 14'h0002);
    exp_cfg("R2 gain code 2");

    wr(2'd2, 14'h3F80);
    exp_cfg("R3 offset -128");
    rd(2'd2, 14'h0080, "R9 offset upper bits read zero");
    wr(2'd2, 14'h007F);
    exp_cfg("R3 offset +127");

    wr(2'd3, 14'h3FFF);
    exp_cfg("R4 ctrl all ones");
    rd(2'd3, 14'h3F80, "R9 ctrl low bits read zero");
    wr(2'd3, 14'h2A80);
    exp_cfg("R4 ctrl pattern a");
    rd(2'd3, 14'h2A80, "R4 ctrl pattern a read");
    wr(2'd3, 14'h1500);
    exp_cfg("R4 ctrl pattern b");

    wr(2'd1, 14'h0007, 1'b1);
    exp_cfg("R5 deselected write ignored");
    rd(2'd1, 14'h0002, "R5 deselected write read");

    // strobe held low: nothing commits until its rising edge
    step();
    cs_n = 1'b0; addr = 2'd1; tb_drv = 14'h0006; tb_en = 1'b1; we_n = 1'b0;
    repeat (6) step();
    push(1, {14'd0, m_ctl, m_ofs, m_gain}, "R5 no commit while strobe low");
    step();
    we_n = 1'b1;
    repeat (2) step();
    cs_n = 1'b1; tb_en = 1'b0;
    repeat (3) step();
    model_wr(2'd1, 14'h0006);
    exp_cfg("R5 commit after rising edge");

    wr(2'd0, 14'h0000);
    exp_cfg("R6 bit0 clear no effect");
    wr(2'd0, 14'h0001);
    exp_cfg("R6 software clear");
    rd(2'd3, 14'h0, "R6 ctrl cleared read");

    result = 14'h2AAA;
    rd(2'd0, 14'h2AAA, "R8 result pattern a");
    result = 14'h1555;
    rd(2'd0, 14'h1555, "R8 result pattern b");

    chk_z(1'b0, 1'b1, "R7 float with read enable high");
    chk_z(1'b1, 1'b0, "R7 float with select high");
    chk_z(1'b1, 1'b1, "R7 float when idle");

    repeat (3) step();
    finish_run();
  end
endmodule